// File: doc/BRIEF.md
# Split-Write Coefficient RAM Loader

This block loads filter coefficients into a local coefficient memory from a 16-bit control bus. Each coefficient is 20 bits wide, signed in two's complement with bit 19 as the sign. Its weights run from 2^0 down to 2^-19. A coefficient takes two bus writes to the coefficient address. The first write carries the top sixteen bits and the second carries the bottom four. Once the second half arrives, the assembled word is stored at an internal load pointer and the pointer steps forward. Entry zero receives the first coefficient written, which is the outer tap.

The load pointer returns to zero in two ways: a synchronous reset, or a rising edge on the filter-disable level. Either event also forgets a half-written coefficient. Neither event alters stored coefficients. This lets software rewrite the whole set from the outer tap inward without touching any other setting. A separate read port lets the filter sequencer fetch any entry by tap index, with one cycle of latency.

Top module: `coef_loader`

## Requirements
- R1: A coefficient is formed from two writes to the coefficient address (bus_addr = 1). The first write supplies bits 19..4 from bus_data[15:0]. The second supplies bits 3..0 from bus_data[3:0]. Bits 15..4 of the second write are ignored.
- R2: Bus writes to any address other than 1 do not store anything. They do not change which half is expected next, and they do not move the load pointer.
- R3: Each completed coefficient is stored at the load pointer, and the pointer then advances by one. The first coefficient completed after a pointer reset lands in entry 0.
- R4: rd_coef presents the content of entry rd_idx on the clock edge after rd_idx is applied.
- R5: While rst is high at a clock edge, the load pointer returns to 0 and any pending upper half is discarded. No stored coefficient changes.
- R6: A 0-to-1 transition of filt_dis returns the load pointer to 0 and discards a pending upper half, leaving stored coefficients intact. Holding filt_dis high or lowering it does not move the pointer, and loading proceeds with filt_dis at either level.
- R7: Once DEPTH coefficients have been stored, further completed coefficients are ignored until the pointer is reset. Entries are never overwritten by wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Control-bus write strobe |
| bus_addr | input | ADDR_W | Control-bus register address |
| bus_data | input | 16 | Control-bus write data |
| filt_dis | input | 1 | Filter-disable level; its rising edge rewinds the load pointer |
| rd_idx | input | clog2(DEPTH) | Tap index read by the filter sequencer |
| rd_coef | output | 20 | Registered coefficient at rd_idx |

## Verification
The assertions assume that filt_dis is a level that changes only between clock edges and is held for at least one cycle. They also assume that a disable rising edge never coincides with a coefficient-address write, because the write is dropped in that case. The stimulus follows both rules: the bench changes filt_dis only in idle cycles, between write pairs. It sweeps every entry of a small-depth instance, interleaves writes to the other addresses, overfills the memory, and checks preserved contents after each kind of pointer reset.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
    localparam int BUS_W  = 16;
    localparam int COEF_W = 20;
    localparam int LO_W   = COEF_W - BUS_W;

    typedef struct packed {
        logic             half;   // 1: upper half held, lower half expected
        logic [BUS_W-1:0] upper;
    } asm_state_t;
endpackage

// File: rtl/coef_half_asm.sv
module coef_half_asm
    import coef_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_hit,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              commit,
    output logic [COEF_W-1:0] word,
    output logic              half
);
    asm_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (clr) begin
            st_d.half = 1'b0;
        end else if (wr_hit) begin
            if (!st_q.half) begin
                st_d.upper = wr_data;
                st_d.half  = 1'b1;
            end else begin
                st_d.half = 1'b0;
                commit    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = {st_q.upper, wr_data[LO_W-1:0]};
    assign half = st_q.half;
endmodule

// File: rtl/coef_ptr_ctrl.sv
module coef_ptr_ctrl #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             filt_dis,
    input  logic             commit,
    output logic             dis_rise,
    output logic             ram_we,
    output logic [IDX_W-1:0] wr_idx,
    output logic [PTR_W-1:0] ptr
);
    typedef struct packed {
        logic             dis;
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic       full;

    always_comb begin
        full     = (st_q.ptr == PTR_W'(DEPTH));
        dis_rise = filt_dis && !st_q.dis;
        ram_we   = commit && !full;
        st_d     = st_q;
        st_d.dis = filt_dis;
        if (dis_rise) begin
            st_d.ptr = '0;
        end else if (ram_we) begin
            st_d.ptr = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_idx = st_q.ptr[IDX_W-1:0];
    assign ptr    = st_q.ptr;
endmodule

// File: rtl/coef_ram.sv
module coef_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = mem_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wr_idx] <= wr_data;
        end
        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/coef_loader.sv
module coef_loader
    import coef_loader_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int ADDR_W    = 2,
    parameter int COEF_ADDR = 1,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              filt_dis,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [COEF_W-1:0] rd_coef
);
    logic              wr_hit;
    logic              dis_rise;
    logic              commit;
    logic              ram_we;
    logic              half_flag;
    logic [COEF_W-1:0] asm_word;
    logic [IDX_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  load_ptr;

    assign wr_hit = bus_wr && (bus_addr == ADDR_W'(COEF_ADDR));

    coef_half_asm u_asm (
        .clk     (clk),
        .rst     (rst),
        .clr     (dis_rise),
        .wr_hit  (wr_hit),
        .wr_data (bus_data),
        .commit  (commit),
        .word    (asm_word),
        .half    (half_flag)
    );

    coef_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .filt_dis (filt_dis),
        .commit   (commit),
        .dis_rise (dis_rise),
        .ram_we   (ram_we),
        .wr_idx   (wr_idx),
        .ptr      (load_ptr)
    );

    coef_ram #(.DEPTH(DEPTH), .WIDTH(COEF_W)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .wr_idx  (wr_idx),
        .wr_data (asm_word),
        .rd_idx  (rd_idx),
        .rd_data (rd_coef)
    );
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             filt_dis,
    input logic             wr_hit,
    input logic             half,
    input logic             ram_we,
    input logic [PTR_W-1:0] ptr
);
    assert_reset_clears_R5: assert property (@(posedge clk)
        rst |=> (ptr == '0) && !half);

    assert_dis_rise_rewinds_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_dis) |=> (ptr == '0) && !half);

    assert_half_toggles_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !$rose(filt_dis)) |=> (half != $past(half)));

    assert_other_addr_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !$rose(filt_dis)) |=> ($stable(half) && $stable(ptr)));

    assert_store_advances_R3: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (ptr == $past(ptr) + PTR_W'(1)));

    assert_ptr_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(DEPTH));
endmodule

bind coef_loader coef_loader_chk #(.DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .filt_dis (filt_dis),
    .wr_hit   (wr_hit),
    .half     (half_flag),
    .ram_we   (ram_we),
    .ptr      (load_ptr)
);

// File: tb/coef_loader_tb_top.sv
module coef_loader_tb_top;
    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [15:0]      bus_data = '0;
    logic             filt_dis = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [19:0]      rd_coef;

    int n_tests = 0;
    int n_fail  = 0;
    logic [19:0] model [DEPTH];

    always #4 clk = ~clk;

    coef_loader #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .filt_dis(filt_dis), .rd_idx(rd_idx),
        .rd_coef(rd_coef)
    );

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_data = '0;
    endtask

    // Low write carries junk in bits 15..4 to show they are dropped (R1).
    task automatic load_coef(input logic [19:0] c);
        bus_write(2'd1, c[19:4]);
        bus_write(2'd1, {12'hA5C ^ c[15:4], c[3:0]});
    endtask

    task automatic check_entry(input int idx, input string req);
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        @(negedge clk);   // one registered stage (R4)
        n_tests++;
        if (rd_coef !== model[idx]) begin
            n_fail++;
            $display("FAIL %s entry %0d: got %05h expected %05h", req, idx, rd_coef, model[idx]);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < DEPTH; i++) check_entry(i, req);
    endtask

    function automatic logic [19:0] pat(input int seed, input int i);
        return 20'((seed * 20'h1357 + i * 20'h2E4B1) ^ (i << 17));
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3, R1: full load from reset, first word at entry 0; R2: other addresses interleaved
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = pat(1, i);
            bus_write(2'd0, 16'hFFFF);
            bus_write(2'd1, model[i][19:4]);
            bus_write(2'd2, 16'h1234);
            bus_write(2'd3, 16'hBEEF);
            bus_write(2'd1, {12'h3C9, model[i][3:0]});
        end
        check_all("R3/R1/R2");
        check_entry(0, "R4 outer tap");

        // R7: memory full, extra coefficients ignored
        load_coef(20'hFFFFF);
        load_coef(20'h00001);
        check_all("R7");

        // R5: reset keeps contents, rewinds pointer
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        check_all("R5 contents kept");
        for (int i = 0; i < 3; i++) begin
            model[i] = pat(7, i);
            load_coef(model[i]);
        end
        check_all("R5 reload from 0");

        // R5: pending upper half discarded by reset
        bus_write(2'd1, 16'hDEAD);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        model[0] = 20'h4B2C7;
        load_coef(model[0]);
        check_all("R5 half cleared");

        // R6: disable rising edge rewinds, keeps contents, clears pending half
        bus_write(2'd1, 16'hCAFE);
        @(negedge clk); filt_dis = 1'b1;
        @(negedge clk);
        check_all("R6 contents kept");
        for (int i = 0; i < 2; i++) begin
            model[i] = pat(11, i);
            load_coef(model[i]);
        end
        check_all("R6 load while disabled");
        // R6: lowering filt_dis does not rewind
        @(negedge clk); filt_dis = 1'b0;
        @(negedge clk);
        model[2] = 20'h80008;
        load_coef(model[2]);
        check_all("R6 fall no rewind");

        // R6 + R7: rewind via disable then refill all entries, overfill
        @(negedge clk); filt_dis = 1'b1;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = pat(23, i);
            load_coef(model[i]);
        end
        load_coef(20'h12345);
        check_all("R6/R7 refill");
        @(negedge clk); filt_dis = 1'b0;

        // R2: writes to other addresses alone store nothing
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        for (int a = 0; a < 4; a++) begin
            if (a != 1) begin
                bus_write(2'(a), 16'h7777);
                bus_write(2'(a), 16'h0008);
            end
        end
        check_all("R2 no store");
        model[0] = 20'h0F0F3;
        load_coef(model[0]);
        check_entry(0, "R2 half unchanged");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule